// File: doc/BRIEF.md
# Manchester Line Encoder

This block sits at the output of a serial transmitter. It turns a stream of NRZ data bits into biphase Manchester II line symbols. A baud generator outside the block supplies two single-cycle strobes. One marks the start of each bit period and the other marks the middle of it. Each data bit becomes two half-bit cells, so the symbol rate on the line is twice the NRZ bit rate. Every encoded bit has a level change at its midpoint, which gives a receiver a timing edge in every bit cell.

Three inputs set how each bit is sent:

- A mode enable chooses between Manchester coding and plain NRZ.
- A polarity input swaps the high-low and low-high mappings.
- A frame-active input tells the encoder whether a bit period carries data. When it does not, the line rests at its idle level.

The block samples the data bit and all three settings on the bit-period strobe and holds them for the whole period. The line output comes from a register.

Top module: `manchester_line_enc`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `line_out` is at the idle level (high with the default `IDLE_LEVEL` of 1).
- R2: With Manchester mode on (`manch_en`=1) and `pol_inv`=0, a data 1 gives a high first half and a data 0 gives a low first half. `line_out` changes on the clock edge where `bit_stb` is high.
- R3: With `pol_inv`=1, the mapping is swapped: a data 1 gives a low first half and a data 0 gives a high first half.
- R4: In Manchester mode, the `half_stb` that follows the bit strobe inverts `line_out` on that edge, so every bit has a mid-cell transition.
- R5: With `manch_en`=0, `line_out` takes the value of `nrz_in` for the whole bit period, and `half_stb` has no effect.
- R6: When `frame_act` is 0 at a bit strobe, `line_out` goes to the idle level, and the following `half_stb` makes no transition.
- R7: `nrz_in`, `manch_en` and `pol_inv` are sampled only on `bit_stb`. Changes between bit strobes do not alter the current bit.
- R8: When `bit_stb` and `half_stb` are high in the same cycle, the bit strobe wins: the encoder starts a new bit in its first half.
- R9: With default polarity, the bits 1,0,1,1,0,0,0,1 (sent first to last) produce the half-cell pairs 10 01 10 10 01 01 01 10.
- R10: In a cycle with neither strobe high, `line_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nrz_in | input | 1 | NRZ data bit, sampled on the bit strobe |
| bit_stb | input | 1 | Single-cycle strobe marking the start of a bit period |
| half_stb | input | 1 | Single-cycle strobe marking the middle of a bit period |
| frame_act | input | 1 | Bit period carries data when high; line is idle when low |
| manch_en | input | 1 | 1 selects Manchester coding, 0 selects NRZ pass-through |
| pol_inv | input | 1 | 1 swaps the Manchester level mapping |
| line_out | output | 1 | Encoded line level, registered |

## Verification
The bench builds the encoder with the default `IDLE_LEVEL` of 1. Both the idle checks and the reset checks therefore expect a high line, which is the resting level of a serial line.

Each bit period in the bench is four clocks long:

- the bit strobe in the first clock,
- a quiet clock,
- the half strobe in the third clock,
- a closing quiet clock.

This spacing brings into reach both holds between strobes and the midpoint transition. Directed bits cover:

- settings that change in the middle of a bit,
- strobes that coincide,
- idle periods,
- a reset that arrives while the line is low.

// File: rtl/mle_pkg.sv
package mle_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic   active;
        logic   manch;
        logic   first_lvl;
        phase_e phase;
    } cell_t;

    localparam cell_t CELL_RESET = '{
        active:    1'b0,
        manch:     1'b0,
        first_lvl: 1'b0,
        phase:     PH_FIRST
    };

    // Level of the opening half-cell for a Manchester bit.
    function automatic logic first_half_level(input logic data, input logic inv);
        return data ^ inv;
    endfunction

    // Line level implied by a cell state.
    function automatic logic cell_level(input cell_t c, input logic idle_lvl);
        logic lvl;
        if (!c.active) begin
            lvl = idle_lvl;
        end else if (!c.manch) begin
            lvl = c.first_lvl;
        end else if (c.phase == PH_FIRST) begin
            lvl = c.first_lvl;
        end else begin
            lvl = ~c.first_lvl;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/mle_cell_gen.sv
module mle_cell_gen
    import mle_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic  bit_stb,
    input  logic  half_stb,
    input  logic  nrz_in,
    input  logic  frame_act,
    input  logic  manch_en,
    input  logic  pol_inv,
    input  cell_t cell_cur,
    output cell_t cell_nxt,
    output logic  lvl_nxt
);

    logic mid_ok;

    // A midpoint strobe only acts on a live Manchester cell still in its first half.
    assign mid_ok = half_stb && cell_cur.active && cell_cur.manch &&
                    (cell_cur.phase == PH_FIRST);

    always_comb begin
        cell_nxt = cell_cur;
        if (bit_stb) begin
            cell_nxt.active    = frame_act;
            cell_nxt.manch     = manch_en;
            cell_nxt.first_lvl = manch_en ? first_half_level(nrz_in, pol_inv) : nrz_in;
            cell_nxt.phase     = PH_FIRST;
        end else if (mid_ok) begin
            cell_nxt.phase = PH_SECOND;
        end
    end

    assign lvl_nxt = cell_level(cell_nxt, IDLE_LEVEL);

endmodule

// File: rtl/mle_state_reg.sv
module mle_state_reg
    import mle_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  cell_t cell_d,
    input  logic  lvl_d,
    output cell_t cell_q,
    output logic  lvl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q <= CELL_RESET;
            lvl_q  <= IDLE_LEVEL;
        end else begin
            cell_q <= cell_d;
            lvl_q  <= lvl_d;
        end
    end

endmodule

// File: rtl/manchester_line_enc.sv
module manchester_line_enc
    import mle_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic nrz_in,
    input  logic bit_stb,
    input  logic half_stb,
    input  logic frame_act,
    input  logic manch_en,
    input  logic pol_inv,
    output logic line_out
);

    cell_t cell_cur;
    cell_t cell_nxt;
    logic  lvl_nxt;

    mle_cell_gen #(
        .IDLE_LEVEL(IDLE_LEVEL)
    ) u_gen (
        .bit_stb  (bit_stb),
        .half_stb (half_stb),
        .nrz_in   (nrz_in),
        .frame_act(frame_act),
        .manch_en (manch_en),
        .pol_inv  (pol_inv),
        .cell_cur (cell_cur),
        .cell_nxt (cell_nxt),
        .lvl_nxt  (lvl_nxt)
    );

    mle_state_reg #(
        .IDLE_LEVEL(IDLE_LEVEL)
    ) u_reg (
        .clk   (clk),
        .rst   (rst),
        .cell_d(cell_nxt),
        .lvl_d (lvl_nxt),
        .cell_q(cell_cur),
        .lvl_q (line_out)
    );

endmodule

// File: rtl/mle_checker.sv
module mle_checker #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic nrz_in,
    input logic bit_stb,
    input logic half_stb,
    input logic frame_act,
    input logic manch_en,
    input logic pol_inv,
    input logic line_out
);

    logic rst_q;
    logic in_first_q;

    // Independent tracker: a Manchester bit in its first half.
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            in_first_q <= 1'b0;
        end else if (bit_stb) begin
            in_first_q <= frame_act && manch_en;
        end else if (half_stb) begin
            in_first_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_idle: assert (line_out == IDLE_LEVEL)
                else $error("line not idle after reset");
        end
    end

    a_r2_default_map: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && frame_act && manch_en && !pol_inv) |=> (line_out == $past(nrz_in)));

    a_r3_swapped_map: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && frame_act && manch_en && pol_inv) |=> (line_out == !$past(nrz_in)));

    a_r4_mid_edge: assert property (@(posedge clk) disable iff (rst)
        (in_first_q && half_stb && !bit_stb) |=> (line_out != $past(line_out)));

    a_r5_nrz_pass: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && frame_act && !manch_en) |=> (line_out == $past(nrz_in)));

    a_r6_idle_rest: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !frame_act) |=> (line_out == IDLE_LEVEL));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!bit_stb && !half_stb) |=> $stable(line_out));

endmodule

bind manchester_line_enc mle_checker #(
    .IDLE_LEVEL(IDLE_LEVEL)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .nrz_in   (nrz_in),
    .bit_stb  (bit_stb),
    .half_stb (half_stb),
    .frame_act(frame_act),
    .manch_en (manch_en),
    .pol_inv  (pol_inv),
    .line_out (line_out)
);

// File: tb/manchester_line_enc_bench.sv
module manchester_line_enc_bench;

    logic clk = 1'b0;
    logic rst;
    logic nrz_in;
    logic bit_stb;
    logic half_stb;
    logic frame_act;
    logic manch_en;
    logic pol_inv;
    logic line_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    manchester_line_enc u_manchester_line_enc (
        .clk      (clk),
        .rst      (rst),
        .nrz_in   (nrz_in),
        .bit_stb  (bit_stb),
        .half_stb (half_stb),
        .frame_act(frame_act),
        .manch_en (manch_en),
        .pol_inv  (pol_inv),
        .line_out (line_out)
    );

    // {data, manch_en, pol_inv, expected first half, expected second half}
    localparam logic [4:0] VEC [12] = '{
        5'b11010, 5'b01001, 5'b11010, 5'b11010,   // R9 stream 1,0,1,1
        5'b01001, 5'b01001, 5'b01001, 5'b11010,   // R9 stream 0,0,0,1
        5'b11101, 5'b01110,                       // R3 swapped polarity
        5'b10011, 5'b00000                        // R5 NRZ pass-through
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Four-clock bit period: bit strobe, quiet, half strobe, quiet.
    task automatic drive_bit(input logic d, input logic m, input logic p,
                             input logic act, input logic both, input logic scramble,
                             output logic s1, output logic sm, output logic s2);
        @(negedge clk);
        nrz_in = d; manch_en = m; pol_inv = p; frame_act = act;
        bit_stb = 1'b1; half_stb = both;
        @(negedge clk);
        s1 = line_out;
        bit_stb = 1'b0; half_stb = 1'b0;
        if (scramble) begin
            nrz_in = ~d; pol_inv = ~p; manch_en = ~m;
        end
        @(negedge clk);
        sm = line_out;
        half_stb = 1'b1;
        @(negedge clk);
        s2 = line_out;
        half_stb = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic s1, sm, s2;
        rst = 1'b1; nrz_in = 1'b0; bit_stb = 1'b0; half_stb = 1'b0;
        frame_act = 1'b0; manch_en = 1'b1; pol_inv = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", line_out, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", line_out, 1'b1);

        for (int i = 0; i < 12; i++) begin
            drive_bit(VEC[i][4], VEC[i][3], VEC[i][2], 1'b1, 1'b0, 1'b0, s1, sm, s2);
            if (i < 8) begin
                chk("R2 first half", s1, VEC[i][1]);
                chk("R9 second half", s2, VEC[i][0]);
            end else if (i < 10) begin
                chk("R3 first half", s1, VEC[i][1]);
                chk("R3 second half", s2, VEC[i][0]);
            end else begin
                chk("R5 first half", s1, VEC[i][1]);
                chk("R5 second half", s2, VEC[i][0]);
            end
            if (i < 10) chk("R4 midpoint", s2, ~s1);
            chk("R10 hold", sm, s1);
        end

        // R6: inactive bit period keeps the line idle
        drive_bit(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, s1, sm, s2);
        chk("R6 idle first", s1, 1'b1);
        chk("R6 idle second", s2, 1'b1);

        // R7: settings changed after the bit strobe are ignored
        drive_bit(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, s1, sm, s2);
        chk("R7 first", s1, 1'b1);
        chk("R7 mid", sm, 1'b1);
        chk("R7 second", s2, 1'b0);

        // R8: coincident strobes start a new bit in its first half
        drive_bit(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, s1, sm, s2);
        chk("R8 first", s1, 1'b0);
        chk("R8 mid", sm, 1'b0);
        chk("R8 second", s2, 1'b1);

        // R1: reset while the line is low
        drive_bit(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, s1, sm, s2);
        chk("R5 low bit", s2, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset from low", line_out, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after second reset", line_out, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule